// File: doc/BRIEF.md
# SPI Command Response Checker

This block sits on the receive side of a host-driven SPI link, behind the serializer. After the host has sent a command frame, the block examines the bytes that come back from the device and decides whether the command succeeded. The result is a one-cycle done pulse and a status code. For single-word reads the block also assembles the returned 32-bit word. For block reads it stops when the data header byte is found and signals this, so that a separate payload engine can take over the transfer.

A command is armed with a `start` pulse that carries the issued opcode and the CRC-enable setting. Received bytes then arrive one per `rx_valid` strobe. The control commands (reset, terminate and repeat) first discard one byte. The block then expects an echo of the opcode, followed by a zero state byte. Read-type commands then search, over a bounded window of bytes, for a header byte whose upper nibble is all ones. The block does not generate the SPI clock and sends no bytes.

Top module: `spi_rsp_checker`

## Requirements
- R1: After reset, `done` and `hdr_found` are 0, `status` is 0 and `rd_data` is 0.
- R2: For opcodes 0xCF, 0xC5 and 0xC6, the first received byte after `start` is discarded and the following byte is taken as the echo.
- R3: If the echo byte differs from the issued opcode, the command finishes on that byte with status FAIL (2'b01).
- R4: If the byte after the echo (the state byte) is not 0x00, the command finishes on that byte with status FAIL.
- R5: For any opcode other than 0xC4, 0xCA, 0xC2 and 0xC8, a zero state byte finishes the command with status OK (2'b00), and `rd_data` reads 0.
- R6: For read opcodes (0xC4, 0xCA, 0xC2, 0xC8), the bytes after the state byte are skipped until one arrives whose bits 7:4 are 4'hF.
- R7: If none of the first HUNT_LIMIT bytes (default 100) after the state byte is a header, the command finishes on the HUNT_LIMIT-th byte with status RESET (2'b10). A header that arrives as exactly the HUNT_LIMIT-th byte is accepted.
- R8: For 0xC4 and 0xCA, the four bytes after the header form `rd_data`, with the first byte in bits 7:0 and the fourth in bits 31:24. With CRC disabled, the command finishes OK on the fourth byte.
- R9: With CRC enabled, word reads consume two more bytes without checking them and finish OK on the second of these.
- R10: For 0xC2 and 0xC8, the header byte finishes the command with status OK, and `hdr_found` is high together with `done`. `hdr_found` is 0 at all other times.
- R11: `done` is a single-cycle pulse in the cycle after the clock edge that samples the final byte. Cycles with `rx_valid` low do not advance the check.
- R12: A `start` pulse while a command is in progress is ignored. Bytes that arrive while no command is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Arms a new check; accepted only when idle |
| opcode | input | 8 | Issued command opcode, sampled with `start` |
| crc_en | input | 1 | Trailing CRC bytes follow word reads, sampled with `start` |
| rx_valid | input | 1 | `rx_byte` holds a received byte this cycle |
| rx_byte | input | 8 | Received byte |
| done | output | 1 | One-cycle pulse: the check has finished |
| status | output | 2 | 00 OK, 01 FAIL, 10 RESET; held until the next finish |
| rd_data | output | 32 | Assembled read word; cleared when a command is accepted |
| hdr_found | output | 1 | Pulses with `done` when a block-read header is found |

## Verification
The hardest situation to reach from the ports is the edge of the header search window. There the outcome changes between OK and RESET on a single byte, and getting there needs a full window of non-header bytes. The stimulus builds two ext-read responses of 100 search bytes each, one that ends in a header and one that does not. It then compares the finishing cycle and the status of each against a byte-walking model in the bench. The same model is used for streams with idle gaps, with a `start` pulse injected mid-command, and with stray bytes before and after a command.

// File: rtl/spi_rsp_chk_pkg.sv
// Package: opcodes, phase and status types shared by the response checker.
// Assumes the opcode byte values used by the device's command set.
package spi_rsp_chk_pkg;

    localparam logic [7:0] OPC_BLK_RD     = 8'hC2;
    localparam logic [7:0] OPC_REG_RD     = 8'hC4;
    localparam logic [7:0] OPC_STOP       = 8'hC5;
    localparam logic [7:0] OPC_AGAIN      = 8'hC6;
    localparam logic [7:0] OPC_BLK_RD_EXT = 8'hC8;
    localparam logic [7:0] OPC_WORD_RD    = 8'hCA;
    localparam logic [7:0] OPC_DEV_RESET  = 8'hCF;

    typedef enum logic [1:0] {
        RSP_OK    = 2'b00,
        RSP_FAIL  = 2'b01,
        RSP_RESET = 2'b10
    } rsp_status_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SKIP,
        PH_ECHO,
        PH_STATE,
        PH_HUNT,
        PH_DATA,
        PH_CRC
    } rsp_phase_t;

    // Control commands whose answer starts one byte late.
    function automatic logic op_has_skip(input logic [7:0] op);
        return (op == OPC_DEV_RESET) || (op == OPC_STOP) || (op == OPC_AGAIN);
    endfunction

    // Single-word reads whose answer carries a data word.
    function automatic logic op_is_word(input logic [7:0] op);
        return (op == OPC_REG_RD) || (op == OPC_WORD_RD);
    endfunction

    // Any read: word reads plus block reads.
    function automatic logic op_is_read(input logic [7:0] op);
        return op_is_word(op) || (op == OPC_BLK_RD) || (op == OPC_BLK_RD_EXT);
    endfunction

endpackage

// File: rtl/spi_rsp_hunt_cnt.sv
// Header-search window counter.
// Counts the non-header bytes seen while searching for a data header.
// at_last flags that the byte being presented now is the final one allowed.
// Assumes LIMIT >= 1 and that clear is applied before each new search.
module spi_rsp_hunt_cnt #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic at_last
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    // Count searched bytes; restart for each accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (clear) cnt <= '0;
        else if (step)  cnt <= cnt + 1'b1;
    end

    assign at_last = (cnt == CW'(LIMIT - 1));

    // R7: a search never steps past its window.
    a_r7_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (cnt < CW'(LIMIT)));
endmodule

// File: rtl/spi_rsp_word_asm.sv
// Read-word assembler.
// Shifts received bytes in from the top, so that the first of WORD_BYTES
// bytes ends in the least significant lane. Cleared when a command is accepted.
module spi_rsp_word_asm #(
    parameter int WORD_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    shift,
    input  logic [7:0]              byte_in,
    output logic [8*WORD_BYTES-1:0] word
);
    localparam int WW = 8 * WORD_BYTES;

    // Hold or shift the data word.
    always_ff @(posedge clk) begin
        if (!rst_n)     word <= '0;
        else if (clear) word <= '0;
        else if (shift) word <= {byte_in, word[WW-1:8]};
    end

    // R8: a shifted byte lands in the top lane one edge later.
    a_r8_top_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !clear) |=> (word[WW-1:WW-8] == $past(byte_in)));
endmodule

// File: rtl/spi_rsp_checker.sv
// SPI command response checker (top).
// Walks the bytes received after a command frame through these steps:
// optional skip byte, opcode echo, state byte, header search, data word and
// trailing CRC. It reports done/status, and for block reads a header flag.
// Assumes one byte per rx_valid strobe and a start pulse issued only after
// the command frame has been sent. CRC bytes are consumed, not checked.
module spi_rsp_checker
    import spi_rsp_chk_pkg::*;
#(
    parameter int HUNT_LIMIT = 100,
    parameter int WORD_BYTES = 4,
    parameter int CRC_BYTES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [7:0]              opcode,
    input  logic                    crc_en,
    input  logic                    rx_valid,
    input  logic [7:0]              rx_byte,
    output logic                    done,
    output logic [1:0]              status,
    output logic [8*WORD_BYTES-1:0] rd_data,
    output logic                    hdr_found
);
    localparam int SEG_MAX = (WORD_BYTES > CRC_BYTES) ? WORD_BYTES : CRC_BYTES;
    localparam int SEG_W   = $clog2(SEG_MAX + 1);

    rsp_phase_t  phase;
    rsp_status_t st_q;
    logic [7:0]  op_q;
    logic        crc_q;
    logic [SEG_W-1:0] seg_cnt;
    logic        accept;
    logic        hunt_step;
    logic        hunt_last;
    logic        is_hdr;

    assign accept    = (phase == PH_IDLE) && start;
    assign is_hdr    = (rx_byte[7:4] == 4'hF);
    assign hunt_step = (phase == PH_HUNT) && rx_valid && !is_hdr;
    assign status    = st_q;

    spi_rsp_hunt_cnt #(.LIMIT(HUNT_LIMIT)) u_hunt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .step    (hunt_step),
        .at_last (hunt_last)
    );

    spi_rsp_word_asm #(.WORD_BYTES(WORD_BYTES)) u_word (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .shift   ((phase == PH_DATA) && rx_valid),
        .byte_in (rx_byte),
        .word    (rd_data)
    );

    // Step through the response bytes and raise the one-cycle result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            st_q      <= RSP_OK;
            op_q      <= '0;
            crc_q     <= 1'b0;
            seg_cnt   <= '0;
            done      <= 1'b0;
            hdr_found <= 1'b0;
        end else begin
            done      <= 1'b0;
            hdr_found <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        op_q  <= opcode;
                        crc_q <= crc_en;
                        phase <= op_has_skip(opcode) ? PH_SKIP : PH_ECHO;
                    end
                end
                PH_SKIP: begin
                    if (rx_valid) phase <= PH_ECHO;
                end
                PH_ECHO: begin
                    if (rx_valid) begin
                        if (rx_byte == op_q) begin
                            phase <= PH_STATE;
                        end else begin
                            phase <= PH_IDLE;
                            done  <= 1'b1;
                            st_q  <= RSP_FAIL;
                        end
                    end
                end
                PH_STATE: begin
                    if (rx_valid) begin
                        if (rx_byte != 8'h00) begin
                            phase <= PH_IDLE;
                            done  <= 1'b1;
                            st_q  <= RSP_FAIL;
                        end else if (op_is_read(op_q)) begin
                            phase <= PH_HUNT;
                        end else begin
                            phase <= PH_IDLE;
                            done  <= 1'b1;
                            st_q  <= RSP_OK;
                        end
                    end
                end
                PH_HUNT: begin
                    if (rx_valid) begin
                        if (is_hdr) begin
                            if (op_is_word(op_q)) begin
                                phase   <= PH_DATA;
                                seg_cnt <= '0;
                            end else begin
                                phase     <= PH_IDLE;
                                done      <= 1'b1;
                                hdr_found <= 1'b1;
                                st_q      <= RSP_OK;
                            end
                        end else if (hunt_last) begin
                            phase <= PH_IDLE;
                            done  <= 1'b1;
                            st_q  <= RSP_RESET;
                        end
                    end
                end
                PH_DATA: begin
                    if (rx_valid) begin
                        if (seg_cnt == SEG_W'(WORD_BYTES - 1)) begin
                            seg_cnt <= '0;
                            if (crc_q) begin
                                phase <= PH_CRC;
                            end else begin
                                phase <= PH_IDLE;
                                done  <= 1'b1;
                                st_q  <= RSP_OK;
                            end
                        end else begin
                            seg_cnt <= seg_cnt + 1'b1;
                        end
                    end
                end
                PH_CRC: begin
                    if (rx_valid) begin
                        if (seg_cnt == SEG_W'(CRC_BYTES - 1)) begin
                            seg_cnt <= '0;
                            phase   <= PH_IDLE;
                            done    <= 1'b1;
                            st_q    <= RSP_OK;
                        end else begin
                            seg_cnt <= seg_cnt + 1'b1;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R11: the result is a single-cycle pulse.
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: a result always follows a sampled byte.
    a_r11_done_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(rx_valid));

    // R10: the header flag only accompanies a successful finish.
    a_r10_hdr_with_ok: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_found |-> (done && (status == 2'b00)));

    // R8: the data-byte index stays inside the word.
    a_r8_seg_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DATA) |-> (seg_cnt < SEG_W'(WORD_BYTES)));

    // R12: an accepted command returns to idle only by finishing.
    a_r12_idle_by_finish: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase) != PH_IDLE && phase == PH_IDLE) |-> done);
endmodule

// File: tb/spi_rsp_checker_test.sv
module spi_rsp_checker_test;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0;
    logic        crc_en = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        done;
    logic [1:0]  status;
    logic [31:0] rd_data;
    logic        hdr_found;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [7:0] stim[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_rsp_checker uut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .crc_en(crc_en), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .done(done), .status(status), .rd_data(rd_data), .hdr_found(hdr_found)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Behavioural model: walk the byte list and find where and how it ends.
    task automatic predict(input logic [7:0] op, input bit crc, output int fin,
                           output logic [1:0] st, output logic [31:0] w,
                           output bit hd);
        int i;
        int n;
        bit ctrl  = (op == 8'hCF) || (op == 8'hC5) || (op == 8'hC6);
        bit wrd   = (op == 8'hC4) || (op == 8'hCA);
        bit blk   = (op == 8'hC2) || (op == 8'hC8);
        fin = -1; st = 2'b00; w = 0; hd = 0;
        i = ctrl ? 1 : 0;
        if (i >= stim.size()) return;
        if (stim[i] != op) begin fin = i; st = 2'b01; return; end
        i++;
        if (i >= stim.size()) return;
        if (stim[i] != 8'h00) begin fin = i; st = 2'b01; return; end
        if (!wrd && !blk) begin fin = i; return; end
        n = 0;
        forever begin
            i++;
            if (i >= stim.size()) return;
            n++;
            if (stim[i][7:4] == 4'hF) break;
            if (n == LIMIT) begin fin = i; st = 2'b10; return; end
        end
        if (blk) begin fin = i; hd = 1; return; end
        if (i + 4 + (crc ? 2 : 0) >= stim.size()) return;
        w = {stim[i+4], stim[i+3], stim[i+2], stim[i+1]};
        fin = i + 4 + (crc ? 2 : 0);
    endtask

    // Issue a command, stream stim with optional gaps, compare on every clock.
    task automatic run(input logic [7:0] op, input bit crc, input int gap,
                       input int busy_idx, input string tag);
        int fin;
        logic [1:0] st;
        logic [31:0] w;
        bit hd;
        predict(op, crc, fin, st, w, hd);
        if (fin < 0) $display("note: stimulus for %s never finishes", tag);
        @(negedge clk);
        start = 1'b1; opcode = op; crc_en = crc;
        @(negedge clk);
        start = 1'b0; opcode = 8'h00; crc_en = 1'b0;
        chk(done == 1'b0, "R11", "done after start", done, 0);
        for (int i = 0; i < stim.size(); i++) begin
            for (int g = 0; g < gap; g++) begin
                rx_valid = 1'b0;
                @(negedge clk);
                chk(done == 1'b0, "R11", "done during gap", done, 0);
            end
            rx_valid = 1'b1; rx_byte = stim[i];
            if (i == busy_idx) begin start = 1'b1; opcode = 8'hC9; end
            @(negedge clk);
            start = 1'b0; opcode = 8'h00;
            if (i == fin) begin
                chk(done == 1'b1, tag, "done at final byte", done, 1);
                chk(status == st, tag, "status", status, st);
                chk(rd_data == w, tag, "rd_data", rd_data, w);
                chk(hdr_found == hd, tag, "hdr_found", hdr_found, hd);
            end else begin
                chk(done == 1'b0, (i > fin && fin >= 0) ? "R12" : "R11",
                    "done off final byte", done, 0);
                chk(hdr_found == 1'b0, "R10", "stray hdr_found", hdr_found, 0);
            end
        end
        rx_valid = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R11", "done after stream", done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(done == 0 && hdr_found == 0, "R1", "flags after reset", {done, hdr_found}, 0);
        chk(status == 2'b00, "R1", "status after reset", status, 0);
        chk(rd_data == 0, "R1", "rd_data after reset", rd_data, 0);

        // R12: stray bytes while idle
        rx_valid = 1'b1; rx_byte = 8'hC9;
        repeat (3) @(negedge clk);
        rx_valid = 1'b0;
        chk(done == 1'b0, "R12", "done from idle bytes", done, 0);

        // R5: plain write, trailing bytes ignored (R12)
        stim = '{8'hC9, 8'h00, 8'h55, 8'hC9};
        run(8'hC9, 0, 0, -1, "R5");
        // R2: reset opcode with skip byte
        stim = '{8'h77, 8'hCF, 8'h00};
        run(8'hCF, 0, 1, -1, "R2");
        stim = '{8'hC5, 8'hC5, 8'h00};
        run(8'hC5, 0, 0, -1, "R2");
        // R2/R3: repeat opcode without skip byte fails echo
        stim = '{8'hC6, 8'h00, 8'h55};
        run(8'hC6, 0, 0, -1, "R3");
        // R3: echo mismatch
        stim = '{8'hC8, 8'h00};
        run(8'hC9, 0, 0, -1, "R3");
        // R4: nonzero state
        stim = '{8'hC9, 8'h04};
        run(8'hC9, 0, 0, -1, "R4");
        stim = '{8'hC4, 8'h80, 8'hF0};
        run(8'hC4, 0, 0, -1, "R4");
        // R6/R8: word read, CRC off, gaps
        stim = '{8'hCA, 8'h00, 8'h00, 8'hE3, 8'hF1, 8'h11, 8'h22, 8'h33, 8'h44, 8'h99};
        run(8'hCA, 0, 2, -1, "R8");
        // R9: word read with CRC
        stim = '{8'hC4, 8'h00, 8'hF3, 8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'h12, 8'h34, 8'h56};
        run(8'hC4, 1, 0, -1, "R9");
        // R10: block read header
        stim = '{8'hC2, 8'h00, 8'h7F, 8'hF0, 8'h01, 8'h02};
        run(8'hC2, 0, 0, -1, "R10");
        // R7: header as the last byte of the window
        stim = '{8'hC8, 8'h00};
        for (int k = 0; k < LIMIT - 1; k++) stim.push_back(8'hE5);
        stim.push_back(8'hF8);
        run(8'hC8, 0, 0, -1, "R7");
        // R7: window expires
        stim = '{8'hC8, 8'h00};
        for (int k = 0; k < LIMIT; k++) stim.push_back(8'h0E);
        stim.push_back(8'hF0);
        stim.push_back(8'h11);
        run(8'hC8, 0, 0, -1, "R7");
        // R12: start while busy is ignored
        stim = '{8'hCA, 8'h00, 8'hFF, 8'h01, 8'h02, 8'h03, 8'h04, 8'hEE, 8'hEE};
        run(8'hCA, 1, 1, 3, "R12");
        // R6: read needs header before data
        stim = '{8'hCA, 8'h00, 8'h5F, 8'h0F, 8'hF0, 8'h9A, 8'hBC, 8'hDE, 8'hF0};
        run(8'hCA, 0, 0, -1, "R6");

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule